// File: doc/BRIEF.md
# Octet-Wide Self-Synchronizing Scrambler/Descrambler

This block randomizes or de-randomizes a byte stream with the self-synchronizing polynomial x^43 + 1, one octet per clock. Each accepted octet is combined by XOR with bits taken from a 43-stage history register. The register then advances by eight positions. The serial recurrence is unrolled eight steps, so eight bit-times are handled in one clock.

A single input, `desc_mode`, chooses between the two directions. When scrambling, the register is loaded with the scrambled bits the block produces. When descrambling, it is loaded with the scrambled bits it receives. A descrambler therefore locks onto any scrambler after 43 bits without any exchange of state. Bit 7 of every octet is the earliest bit on the line. The result is registered and appears one clock after the octet is accepted.

Top module: `sss_octet_scrambler`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears all 43 history stages, `dout` and `dout_vld` to zero.
- R2: `dout_vld` is high in exactly the cycle after a cycle with `din_vld` high. After a cycle with `din_vld` low it is low.
- R3: For an accepted octet, `dout[7-i] = din[7-i] XOR stage(43-i)` for i = 0..7, using the history before the update. Stage 43 pairs with bit 7, the earliest bit. As a result, starting from the reset state with `desc_mode` = 0 and first octet A, the first five octets pass unchanged and the sixth octet is XORed with A >> 3.
- R4: With `desc_mode` = 0 (scramble), an accepted octet moves stages 1..35 into stages 9..43. Stage j (j = 1..8) receives produced output bit j-1, so the most recent bit lands in stage 1.
- R5: With `desc_mode` = 1 (descramble), the shift is the same as in R4, but stage j receives received input bit `din[j-1]`.
- R6: While `din_vld` is low the history holds its value. Idle cycles inserted into a stream do not change later outputs.
- R7: A descrambler fed by a scrambler's output reproduces the original data from the seventh octet on (after 43 bits), whatever state it starts in.
- R8: In both modes, the output sequence equals that of a bit-serial x^43 + 1 scrambler or descrambler processing the bits MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| desc_mode | input | 1 | 0 = scramble, 1 = descramble |
| din_vld | input | 1 | Octet on `din` is accepted this cycle |
| din | input | 8 | Input octet, bit 7 earliest |
| dout_vld | output | 1 | `dout` carries a new result |
| dout | output | 8 | Scrambled or descrambled octet, bit 7 earliest |

## Verification
Several behaviours are checked on every cycle by the assertions: the one-cycle valid timing, the hold of history over idle cycles, and the octet being combined with the eight oldest stages. They also check which stream refills the youngest eight stages in each mode. The exact bit ordering against a serial x^43 + 1 recurrence can only be shown by the bench's scenarios. The same holds for the lock of a descrambler started from a foreign state, the clean restart after a mid-stream reset, and the hand-derived A >> 3 pattern after reset.

// File: rtl/sss_pkg.sv
// Shared constants and types for the octet-wide self-synchronizing scrambler.
package sss_pkg;
    localparam int unsigned SSS_LEN = 43;  // history stages (polynomial degree)
    localparam int unsigned SSS_W   = 8;   // bits handled per clock

    typedef enum logic {
        SSS_SCRAMBLE   = 1'b0,
        SSS_DESCRAMBLE = 1'b1
    } sss_mode_e;
endpackage

// File: rtl/sss_keytap.sv
// Picks the W oldest history stages as the key for one word.
// Assumes W <= LEN. Key bit m pairs with data bit m; the MSB (earliest bit)
// pairs with stage LEN.
module sss_keytap #(
    parameter int unsigned LEN = 43,
    parameter int unsigned W   = 8
) (
    input  logic [LEN:1]  hist_i,
    output logic [W-1:0]  key_o
);
    for (genvar m = 0; m < W; m++) begin : g_tap
        // bit W-1-i sees stage LEN-i
        assign key_o[m] = hist_i[LEN-W+1+m];
    end
endmodule

// File: rtl/sss_mix.sv
// Combines data with the key and chooses the stream that refills the history.
// Assumes the key comes from the history before this word's update.
module sss_mix #(
    parameter int unsigned W = 8
) (
    input  sss_pkg::sss_mode_e mode_i,
    input  logic [W-1:0]       data_i,
    input  logic [W-1:0]       key_i,
    output logic [W-1:0]       mixed_o,
    output logic [W-1:0]       feed_o
);
    // XOR data with key; the scrambler loops its own output, the descrambler its input
    always_comb begin
        mixed_o = data_i ^ key_i;
        feed_o  = (mode_i == sss_pkg::SSS_DESCRAMBLE) ? data_i : mixed_o;
    end
endmodule

// File: rtl/sss_history.sv
// LEN-stage history register advancing W positions per enabled clock.
// Stage j (1..W) takes feed bit j-1, so the newest bit lands in stage 1.
// Assumes LEN > W. Synchronous active-low reset clears all stages.
module sss_history #(
    parameter int unsigned LEN = 43,
    parameter int unsigned W   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en_i,
    input  logic [W-1:0]   feed_i,
    output logic [LEN:1]   hist_o
);
    logic [LEN:1] hist_q;

    // age the history by one word on each accepted input
    always_ff @(posedge clk) begin
        if (!rst_n)          hist_q <= '0;
        else if (shift_en_i) hist_q <= {hist_q[LEN-W:1], feed_i};
    end

    assign hist_o = hist_q;

    // R6: no accepted word, no change
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> $stable(hist_q));
endmodule

// File: rtl/sss_octet_scrambler.sv
// Octet-wide self-synchronizing scrambler/descrambler, polynomial x^LEN + 1.
// One word per clock when din_vld is high; result registered, one cycle latency.
// Assumes din bit W-1 is the earliest bit on the line.
module sss_octet_scrambler
    import sss_pkg::*;
#(
    parameter int unsigned LEN = SSS_LEN,
    parameter int unsigned W   = SSS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_mode,
    input  logic          din_vld,
    input  logic [W-1:0]  din,
    output logic          dout_vld,
    output logic [W-1:0]  dout
);
    logic [LEN:1] hist;
    logic [W-1:0] key;
    logic [W-1:0] mixed;
    logic [W-1:0] feed;
    sss_mode_e    mode;

    assign mode = desc_mode ? SSS_DESCRAMBLE : SSS_SCRAMBLE;

    sss_keytap #(.LEN(LEN), .W(W)) u_tap (
        .hist_i (hist),
        .key_o  (key)
    );

    sss_mix #(.W(W)) u_mix (
        .mode_i  (mode),
        .data_i  (din),
        .key_i   (key),
        .mixed_o (mixed),
        .feed_o  (feed)
    );

    sss_history #(.LEN(LEN), .W(W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (din_vld),
        .feed_i     (feed),
        .hist_o     (hist)
    );

    // register the result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_vld <= 1'b0;
            dout     <= '0;
        end else begin
            dout_vld <= din_vld;
            if (din_vld) dout <= mixed;
        end
    end

    // R2: strobe follows the input strobe by one cycle
    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> dout_vld);
    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> !dout_vld);
    // R3: output differs from input by exactly the oldest W stages
    a_r3_key_applied: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> ((dout ^ $past(din)) == $past(hist[LEN:LEN-W+1])));
    // R4: scrambler refills with what it emitted
    a_r4_feed_scrambled: assert property (@(posedge clk) disable iff (!rst_n)
        (din_vld && !desc_mode) |=> (hist[W:1] == dout));
    // R5: descrambler refills with what it received
    a_r5_feed_received: assert property (@(posedge clk) disable iff (!rst_n)
        (din_vld && desc_mode) |=> (hist[W:1] == $past(din)));
endmodule

// File: tb/sim_sss_octet_scrambler.sv
module sim_sss_octet_scrambler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       din_vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic       dout_vld;
    logic [7:0] dout;

    // second instance: descrambler, fed by the bench or chained to u0
    logic       chain = 1'b0;
    logic       pre_vld = 1'b0;
    logic [7:0] pre_d = 8'h00;
    logic       d1_vld;
    logic [7:0] d1_din;
    logic       q1_vld;
    logic [7:0] q1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [43:1] ref_h;
    logic [7:0]  sent [0:63];

    localparam logic [7:0] STIM [16] = '{
        8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h7E, 8'h12, 8'hED,
        8'h55, 8'hAA, 8'h0F, 8'hF0, 8'hC3, 8'h96, 8'h01, 8'h80
    };

    always #5 clk = ~clk;

    sss_octet_scrambler u0 (
        .clk(clk), .rst_n(rst_n), .desc_mode(mode),
        .din_vld(din_vld), .din(din), .dout_vld(dout_vld), .dout(dout)
    );

    assign d1_vld = chain ? dout_vld : pre_vld;
    assign d1_din = chain ? dout : pre_d;

    sss_octet_scrambler u_desc (
        .clk(clk), .rst_n(rst_n), .desc_mode(1'b1),
        .din_vld(d1_vld), .din(d1_din), .dout_vld(q1_vld), .dout(q1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bit-serial x^43+1 reference, MSB first (R8)
    task automatic ref_run(input logic m, input logic [7:0] x, output logic [7:0] y);
        for (int b = 7; b >= 0; b--) begin
            y[b] = x[b] ^ ref_h[43];
            ref_h = {ref_h[42:1], (m ? x[b] : y[b])};
        end
    endtask

    // inputs change just after a falling edge; outputs read at the next one
    task automatic drive(input logic v, input logic [7:0] d);
        din_vld = v;
        din = d;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; din_vld = 1'b0; pre_vld = 1'b0; chain = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        ref_h = '0;
    endtask

    initial begin
        logic [7:0] e;
        @(negedge clk);
        do_reset();
        // R1: reset state at the ports
        chk("R1 dout_vld", {31'd0, dout_vld}, 0);
        chk("R1 dout", {24'd0, dout}, 0);

        // table walk in both modes against the serial reference (R8, R2)
        for (int md = 0; md < 2; md++) begin
            do_reset();
            mode = md[0];
            for (int i = 0; i < 16; i++) begin
                ref_run(mode, STIM[i], e);
                drive(1'b1, STIM[i]);
                chk("R2 valid", {31'd0, dout_vld}, 1);
                chk(md == 0 ? "R8 R4 scramble" : "R8 R5 descramble", {24'd0, dout}, {24'd0, e});
            end
        end

        // R3: hand-derived key after reset: first octet FF reappears >>3 in octet six
        for (int md = 0; md < 2; md++) begin
            do_reset();
            mode = md[0];
            drive(1'b1, 8'hFF);
            chk("R3 first octet passes", {24'd0, dout}, 32'hFF);
            for (int i = 1; i < 5; i++) begin
                drive(1'b1, 8'h00);
                chk("R3 zero key", {24'd0, dout}, 0);
            end
            drive(1'b1, 8'h00);
            chk("R3 sixth octet key", {24'd0, dout}, 32'h1F);
        end

        // R6: idle gaps leave the stream unchanged
        do_reset();
        mode = 1'b0;
        for (int i = 0; i < 10; i++) begin
            ref_run(1'b0, STIM[i] ^ 8'h5A, e);
            drive(1'b1, STIM[i] ^ 8'h5A);
        end
        for (int g = 0; g < 3; g++) begin
            drive(1'b0, 8'hEE);
            chk("R6 R2 idle strobe", {31'd0, dout_vld}, 0);
        end
        for (int i = 0; i < 10; i++) begin
            ref_run(1'b0, STIM[15-i], e);
            drive(1'b1, STIM[15-i]);
            chk("R6 after gap", {24'd0, dout}, {24'd0, e});
        end

        // R1: reset in mid-stream restarts from a clear history
        rst_n = 1'b0; din_vld = 1'b0;
        @(negedge clk);
        chk("R1 mid-stream strobe", {31'd0, dout_vld}, 0);
        chk("R1 mid-stream data", {24'd0, dout}, 0);
        rst_n = 1'b1;
        drive(1'b1, 8'hFF);
        for (int i = 1; i < 5; i++) drive(1'b1, 8'h00);
        drive(1'b1, 8'h00);
        chk("R1 R3 clear after reset", {24'd0, dout}, 32'h1F);

        // R7: descrambler starts from a foreign state, then locks onto u0
        do_reset();
        mode = 1'b0;
        for (int i = 0; i < 7; i++) begin
            pre_vld = 1'b1; pre_d = 8'h3B + 8'(i * 29);
            @(negedge clk);
        end
        pre_vld = 1'b0;
        chain = 1'b1;
        for (int n = 0; n < 48; n++) begin
            sent[n] = 8'(n * 37 + 5) ^ 8'hC6;
            ref_run(1'b0, sent[n], e);
            drive(1'b1, sent[n]);
            chk("R8 chained scrambler", {24'd0, dout}, {24'd0, e});
            if (n >= 7) chk("R7 recovery", {24'd0, q1}, {24'd0, sent[n-1]});
        end
        drive(1'b0, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule